// File: doc/BRIEF.md
# TDD Rate-Matching Buffer Controller

This block sits between a voice codec and a radio that share one time-division duplex link. The codec exchanges bytes at a slow, steady rate in both directions. The radio moves bytes much faster, but in one direction at a time. The controller holds one ring buffer for each direction. It uses a pair of down-counters for each direction, one for bytes in and one for bytes out. Both counters are loaded with the buffer depth when a phase begins. It steps through five phases: fill, transmit settle, transmit burst, receive settle and receive run.

On the transmit side, codec bytes are stored until the input counter drops to a launch level. At that point the buffer already holds enough data that the faster radio can drain it without running dry. The controller then waits a fixed settle time for the synthesizer and opens the burst. On the receive side, it waits a shorter settle time before enabling the radio. It then drops the leading header bytes of each frame, stores the payload, and serves codec read requests as soon as the first payload byte is stored. A sticky error flag records any byte that has nowhere to go.

Top module: `tdd_rate_ctrl`

## Requirements
- R1: Reset state: phase fill, `radio_tx_en_o` and `radio_rx_en_o` low, both valid outputs low, `err_o` low. Transmit counters hold DEPTH and receive counters hold 0.
- R2: A codec input byte is stored whenever the transmit input counter is nonzero, and each stored byte decrements that counter. The counter is loaded with DEPTH at reset and at the end of every burst. The radio receives every stored byte exactly once.
- R3: Once the transmit input counter is at or below LAUNCH_LEVEL (default 34) during fill, a settle window of `(CLK_HZ/1000)*TX_SETTLE_US/1000` cycles begins (750 µs by default). `radio_tx_en_o` rises right after that window.
- R4: During the burst, a `radio_tx_req_i` with stored data and a nonzero output counter returns the oldest byte on `radio_tx_data_o`, with `radio_tx_valid_o` high in the next cycle. Requests outside the burst return nothing.
- R5: The burst ends when both transmit counters are 0. `radio_tx_en_o` then falls, and `radio_rx_en_o` rises after a settle window of `(CLK_HZ/1000)*RX_SETTLE_US/1000` cycles (250 µs by default).
- R6: In each receive phase, the first HDR_BYTES (default 4) radio bytes are discarded and never reach the codec. Radio bytes that arrive while `radio_rx_en_o` is low are ignored.
- R7: A `codec_out_req_i` is served once a payload byte is stored: the oldest byte appears on `codec_out_data_o` with `codec_out_valid_o` high in the next cycle. A request with nothing stored returns no valid.
- R8: The receive phase ends when both receive counters are 0. Each receive phase delivers exactly DEPTH bytes to the codec, and the controller then returns to fill.
- R9: Buffer addresses wrap modulo DEPTH, including depths that are not a power of two, and the byte order is kept across the wrap.
- R10: `err_o` goes high, and stays high until reset, on any of three events: a codec byte arriving while the transmit input counter is 0, a burst request with nothing stored, or a payload byte arriving while the receive input counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| codec_in_valid_i | input | 1 | Codec delivers a byte this cycle |
| codec_in_data_i | input | DATA_W | Codec byte to transmit |
| codec_out_req_i | input | 1 | Codec asks for a received byte |
| codec_out_data_o | output | DATA_W | Received byte for the codec |
| codec_out_valid_o | output | 1 | `codec_out_data_o` holds a fresh byte |
| radio_tx_req_i | input | 1 | Radio asks for the next transmit byte |
| radio_tx_data_o | output | DATA_W | Byte for the radio |
| radio_tx_valid_o | output | 1 | `radio_tx_data_o` holds a fresh byte |
| radio_tx_en_o | output | 1 | Transmit burst is open |
| radio_rx_valid_i | input | 1 | Radio delivers a received byte |
| radio_rx_data_i | input | DATA_W | Received radio byte |
| radio_rx_en_o | output | 1 | Receive phase is open |
| err_o | output | 1 | Sticky overflow/underflow flag |

## Verification
The bench builds the block with DEPTH 12, LAUNCH_LEVEL 5, HDR_BYTES 2 and CLK_HZ 20000, which gives settle windows of 15 and 5 cycles. These values let a few thousand cycles cover more than five full duplex rounds. Both ring pointers wrap once per phase at a depth that is not a power of two. Each launch and settle edge can be lined up against the reference model cycle by cycle. The last stretch floods the codec input so that the sticky error can be seen going high and staying high.

// File: rtl/tdd_pkg.sv
// Shared types for the TDD rate-matching controller.
// Assumes: settle times are given in microseconds, and the clock in Hz.
package tdd_pkg;

    typedef enum logic [2:0] {
        PH_FILL  = 3'd0,
        PH_TXSET = 3'd1,
        PH_BURST = 3'd2,
        PH_RXSET = 3'd3,
        PH_RXRUN = 3'd4
    } phase_t;

    // Turns a settle time in microseconds into clock cycles, with a minimum of one.
    function automatic int settle_cycles(int clk_hz, int us);
        int c;
        c = (clk_hz / 1000) * us / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/tdd_ring.sv
// Byte ring buffer for one direction. Addresses wrap modulo DEPTH.
// Read data is registered, so it appears one cycle after re_i.
// Assumes: the parent never writes when full and never reads when empty.
module tdd_ring #(
    parameter int DEPTH  = 80,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              re_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              empty_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST    = AW'(DEPTH - 1);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;
    logic [CW-1:0]     count;

    assign empty_o = (count == '0);

    // Storage array write; it has no reset because it is plain storage.
    always_ff @(posedge clk) begin
        if (we_i) mem[wptr] <= wdata_i;
    end

    // Pointer, fill level and read register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            count   <= '0;
            rdata_o <= '0;
        end else begin
            if (we_i) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (re_i) begin
                rdata_o <= mem[rptr];
                rptr    <= (rptr == LAST) ? '0 : rptr + 1'b1;
            end
            case ({we_i, re_i})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    a_r9_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> (count < DEPTH_C) || re_i);
    a_r7_no_underrun: assert property (@(posedge clk) disable iff (!rst_n)
        re_i |-> (count != '0));

endmodule

// File: rtl/tdd_settle_timer.sv
// Down-counter that times the settle window. A load sets the count.
// done_o is high whenever the count is zero.
// Assumes: load_val_i fits within TW bits.
module tdd_settle_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] load_val_i,
    output logic          done_o
);
    logic [TW-1:0] cnt;

    assign done_o = (cnt == '0);

    // A load takes priority; otherwise the count runs down to zero and stops.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (load_i)      cnt <= load_val_i;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

endmodule

// File: rtl/tdd_rate_ctrl.sv
// TDD rate-matching buffer controller (top). It matches a slow full-duplex
// codec byte stream to a fast half-duplex radio using one ring per direction
// and in/out down-counters that are loaded with DEPTH at the start of a phase.
// Assumes: the radio drains faster than the codec fills once launched.
module tdd_rate_ctrl
    import tdd_pkg::*;
#(
    parameter int DEPTH        = 80,
    parameter int LAUNCH_LEVEL = 34,
    parameter int HDR_BYTES    = 4,
    parameter int DATA_W       = 8,
    parameter int CLK_HZ       = 50_000_000,
    parameter int TX_SETTLE_US = 750,
    parameter int RX_SETTLE_US = 250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              codec_in_valid_i,
    input  logic [DATA_W-1:0] codec_in_data_i,
    input  logic              codec_out_req_i,
    output logic [DATA_W-1:0] codec_out_data_o,
    output logic              codec_out_valid_o,
    input  logic              radio_tx_req_i,
    output logic [DATA_W-1:0] radio_tx_data_o,
    output logic              radio_tx_valid_o,
    output logic              radio_tx_en_o,
    input  logic              radio_rx_valid_i,
    input  logic [DATA_W-1:0] radio_rx_data_i,
    output logic              radio_rx_en_o,
    output logic              err_o
);
    localparam int CW      = $clog2(DEPTH + 1);
    localparam int HW      = $clog2(HDR_BYTES + 2);
    localparam int TX_CYC  = settle_cycles(CLK_HZ, TX_SETTLE_US);
    localparam int RX_CYC  = settle_cycles(CLK_HZ, RX_SETTLE_US);
    localparam int MAX_CYC = (TX_CYC > RX_CYC) ? TX_CYC : RX_CYC;
    localparam int TW      = $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] DEPTH_C  = CW'(DEPTH);
    localparam logic [CW-1:0] LAUNCH_C = CW'(LAUNCH_LEVEL);
    localparam logic [HW-1:0] HDR_C    = HW'(HDR_BYTES);
    localparam logic [TW-1:0] TX_LOAD  = TW'(TX_CYC - 1);
    localparam logic [TW-1:0] RX_LOAD  = TW'(RX_CYC - 1);

    phase_t        state, state_n;
    logic [CW-1:0] tx_in_cnt, tx_out_cnt, rx_in_cnt, rx_out_cnt;
    logic [HW-1:0] hdr_cnt;
    logic          tx_empty, rx_empty, tmr_done, tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tx_wr, tx_rd, tx_over, tx_under;
    logic          rx_take, hdr_skip, rx_wr, rx_over, rx_rd;
    logic          tx_done, rx_done, start_rx;

    tdd_ring #(.DEPTH(DEPTH), .DATA_W(DATA_W)) tx_ring_i (
        .clk(clk), .rst_n(rst_n),
        .we_i(tx_wr), .wdata_i(codec_in_data_i),
        .re_i(tx_rd), .rdata_o(radio_tx_data_o), .empty_o(tx_empty)
    );

    tdd_ring #(.DEPTH(DEPTH), .DATA_W(DATA_W)) rx_ring_i (
        .clk(clk), .rst_n(rst_n),
        .we_i(rx_wr), .wdata_i(radio_rx_data_i),
        .re_i(rx_rd), .rdata_o(codec_out_data_o), .empty_o(rx_empty)
    );

    tdd_settle_timer #(.TW(TW)) settle_i (
        .clk(clk), .rst_n(rst_n),
        .load_i(tmr_load), .load_val_i(tmr_val), .done_o(tmr_done)
    );

    // Per-cycle byte moves, accepted or refused, in both directions.
    always_comb begin
        tx_wr    = codec_in_valid_i && (tx_in_cnt != '0);
        tx_over  = codec_in_valid_i && (tx_in_cnt == '0);
        tx_rd    = (state == PH_BURST) && radio_tx_req_i && (tx_out_cnt != '0) && !tx_empty;
        tx_under = (state == PH_BURST) && radio_tx_req_i && !tx_rd;
        rx_take  = (state == PH_RXRUN) && radio_rx_valid_i;
        hdr_skip = rx_take && (hdr_cnt != '0);
        rx_wr    = rx_take && (hdr_cnt == '0) && (rx_in_cnt != '0);
        rx_over  = rx_take && (hdr_cnt == '0) && (rx_in_cnt == '0);
        rx_rd    = codec_out_req_i && (rx_out_cnt != '0) && !rx_empty;
        tx_done  = (tx_in_cnt == '0) && (tx_out_cnt == '0);
        rx_done  = (rx_in_cnt == '0) && (rx_out_cnt == '0);
        start_rx = (state == PH_BURST) && tx_done;
    end

    // Phase sequencing and settle timer loads.
    always_comb begin
        state_n  = state;
        tmr_load = 1'b0;
        tmr_val  = TX_LOAD;
        case (state)
            PH_FILL:  if (tx_in_cnt <= LAUNCH_C) begin
                          state_n  = PH_TXSET;
                          tmr_load = 1'b1;
                      end
            PH_TXSET: if (tmr_done) state_n = PH_BURST;
            PH_BURST: if (tx_done) begin
                          state_n  = PH_RXSET;
                          tmr_load = 1'b1;
                          tmr_val  = RX_LOAD;
                      end
            PH_RXSET: if (tmr_done) state_n = PH_RXRUN;
            PH_RXRUN: if (rx_done) state_n = PH_FILL;
            default:  state_n = PH_FILL;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PH_FILL;
        else        state <= state_n;
    end

    // Down-counters: loaded at the start of a phase, decremented per byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_in_cnt  <= DEPTH_C;
            tx_out_cnt <= DEPTH_C;
            rx_in_cnt  <= '0;
            rx_out_cnt <= '0;
            hdr_cnt    <= '0;
        end else if (start_rx) begin
            tx_in_cnt  <= DEPTH_C;
            tx_out_cnt <= DEPTH_C;
            rx_in_cnt  <= DEPTH_C;
            rx_out_cnt <= DEPTH_C;
            hdr_cnt    <= HDR_C;
        end else begin
            if (tx_wr)    tx_in_cnt  <= tx_in_cnt - 1'b1;
            if (tx_rd)    tx_out_cnt <= tx_out_cnt - 1'b1;
            if (rx_wr)    rx_in_cnt  <= rx_in_cnt - 1'b1;
            if (rx_rd)    rx_out_cnt <= rx_out_cnt - 1'b1;
            if (hdr_skip) hdr_cnt    <= hdr_cnt - 1'b1;
        end
    end

    // Output strobes and the sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            radio_tx_valid_o  <= 1'b0;
            codec_out_valid_o <= 1'b0;
            err_o             <= 1'b0;
        end else begin
            radio_tx_valid_o  <= tx_rd;
            codec_out_valid_o <= rx_rd;
            if (tx_over || tx_under || rx_over) err_o <= 1'b1;
        end
    end

    assign radio_tx_en_o = (state == PH_BURST);
    assign radio_rx_en_o = (state == PH_RXRUN);

    a_r2_out_trails_in: assert property (@(posedge clk) disable iff (!rst_n)
        tx_out_cnt >= tx_in_cnt);
    a_r3_launch_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(radio_tx_en_o) |-> $past(state == PH_TXSET));
    a_r3_settle_at_level: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_TXSET && $past(state == PH_FILL)) |-> $past(tx_in_cnt) <= LAUNCH_C);
    a_r4_tx_valid_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        radio_tx_valid_o |-> $past(radio_tx_en_o));
    a_r5_rx_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(radio_rx_en_o) |-> $past(state == PH_RXSET));
    a_r7_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        codec_out_valid_o |-> $past(codec_out_req_i));
    a_r5_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(radio_tx_en_o && radio_rx_en_o));
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

endmodule

// File: tb/tdd_rate_ctrl_tb_top.sv
// Bench for tdd_rate_ctrl: a behavioural reference model built on queues,
// stepped with the same inputs and compared with the DUT on every clock.
module tdd_rate_ctrl_tb_top;
    localparam int DEPTH = 12, LAUNCH = 5, HDR = 2, DW = 8, HZ = 20_000;
    localparam int TXC = 15, RXC = 5;
    localparam int P_FILL = 0, P_TXSET = 1, P_BURST = 2, P_RXSET = 3, P_RXRUN = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cin_v = 1'b0, cout_req = 1'b0, rtx_req = 1'b0, rrx_v = 1'b0;
    logic [DW-1:0] cin_d = '0, rrx_d = '0;
    logic [DW-1:0] cout_d, rtx_d;
    logic cout_v, rtx_v, rtx_en, rrx_en, err;

    always #10 clk = ~clk;

    tdd_rate_ctrl #(.DEPTH(DEPTH), .LAUNCH_LEVEL(LAUNCH), .HDR_BYTES(HDR), .DATA_W(DW),
                    .CLK_HZ(HZ), .TX_SETTLE_US(750), .RX_SETTLE_US(250)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .codec_in_valid_i(cin_v), .codec_in_data_i(cin_d),
        .codec_out_req_i(cout_req), .codec_out_data_o(cout_d), .codec_out_valid_o(cout_v),
        .radio_tx_req_i(rtx_req), .radio_tx_data_o(rtx_d), .radio_tx_valid_o(rtx_v),
        .radio_tx_en_o(rtx_en), .radio_rx_valid_i(rrx_v), .radio_rx_data_i(rrx_d),
        .radio_rx_en_o(rrx_en), .err_o(err)
    );

    int checks = 0, fails = 0;
    bit finished = 0;

    // Reference model state
    int m_st = P_FILL, m_tmr = 0;
    int m_tin = DEPTH, m_tout = DEPTH, m_rin = 0, m_rout = 0, m_hdr = 0;
    bit m_err = 0, m_txv = 0, m_cov = 0;
    logic [DW-1:0] m_txd = '0, m_cod = '0;
    logic [DW-1:0] txq[$], rxq[$];

    // Counts seen at the DUT ports
    int seen_tx_phases = 0, seen_rx_phases = 0, seen_tx_bytes = 0, seen_cod_bytes = 0;
    bit prev_txen = 0, prev_rxen = 0;

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Advance the model by one clock, using the inputs that are being driven.
    task automatic model_step();
        int nst = m_st, ntmr = m_tmr;
        int ntin = m_tin, ntout = m_tout, nrin = m_rin, nrout = m_rout, nhdr = m_hdr;
        bit tx_empty = (txq.size() == 0);
        bit rx_empty = (rxq.size() == 0);
        m_txv = 0;
        m_cov = 0;
        if (cin_v) begin
            if (m_tin != 0) begin txq.push_back(cin_d); ntin--; end
            else m_err = 1;
        end
        if (m_st == P_BURST && rtx_req) begin
            if (m_tout != 0 && !tx_empty) begin m_txv = 1; m_txd = txq.pop_front(); ntout--; end
            else m_err = 1;
        end
        if (m_st == P_RXRUN && rrx_v) begin
            if (m_hdr != 0) nhdr--;
            else if (m_rin != 0) begin rxq.push_back(rrx_d); nrin--; end
            else m_err = 1;
        end
        if (cout_req && m_rout != 0 && !rx_empty) begin
            m_cov = 1; m_cod = rxq.pop_front(); nrout--;
        end
        case (m_st)
            P_FILL:  if (m_tin <= LAUNCH) begin nst = P_TXSET; ntmr = TXC - 1; end
            P_TXSET: if (m_tmr == 0) nst = P_BURST; else ntmr--;
            P_BURST: if (m_tin == 0 && m_tout == 0) begin
                         nst = P_RXSET; ntmr = RXC - 1;
                         ntin = DEPTH; ntout = DEPTH; nrin = DEPTH; nrout = DEPTH; nhdr = HDR;
                     end
            P_RXSET: if (m_tmr == 0) nst = P_RXRUN; else ntmr--;
            default: if (m_rin == 0 && m_rout == 0) nst = P_FILL;
        endcase
        m_st = nst; m_tmr = ntmr;
        m_tin = ntin; m_tout = ntout; m_rin = nrin; m_rout = nrout; m_hdr = nhdr;
    endtask

    // Compare the DUT ports with the model, and count phases and bytes.
    task automatic compare();
        chk(rtx_en == (m_st == P_BURST), "R3", "radio_tx_en", rtx_en, m_st == P_BURST);
        chk(rrx_en == (m_st == P_RXRUN), "R5", "radio_rx_en", rrx_en, m_st == P_RXRUN);
        chk(rtx_v == m_txv, "R4", "radio_tx_valid", rtx_v, m_txv);
        if (m_txv) chk(rtx_d == m_txd, "R2 R4 R9", "radio_tx_data", rtx_d, m_txd);
        chk(cout_v == m_cov, "R7", "codec_out_valid", cout_v, m_cov);
        if (m_cov) chk(cout_d == m_cod, "R6 R7 R9", "codec_out_data", cout_d, m_cod);
        chk(err == m_err, "R10", "err", err, m_err);
        if (prev_txen && !rtx_en) seen_tx_phases++;
        if (prev_rxen && !rrx_en) seen_rx_phases++;
        if (rtx_v) seen_tx_bytes++;
        if (cout_v) seen_cod_bytes++;
        prev_txen = rtx_en;
        prev_rxen = rrx_en;
    endtask

    // Choose this cycle's inputs; flood selects the error-provoking mode.
    task automatic drive(bit flood);
        cin_v = flood ? 1'b1 : (m_tin != 0 && $urandom_range(3) == 0);
        cin_d = DW'($urandom);
        if (m_st == P_BURST) rtx_req = (txq.size() > 0) && ($urandom_range(2) != 0);
        else                 rtx_req = ($urandom_range(7) == 0);   // R4: ignored
        if (m_st == P_RXRUN) rrx_v = (m_hdr != 0 || m_rin != 0) && ($urandom_range(1) == 0);
        else                 rrx_v = ($urandom_range(7) == 0);     // R6: ignored
        rrx_d = DW'($urandom);
        cout_req = ($urandom_range(2) == 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state at the ports
        chk(!rtx_en && !rrx_en, "R1", "enables after reset", {rtx_en, rrx_en}, 0);
        chk(!rtx_v && !cout_v, "R1", "valids after reset", {rtx_v, cout_v}, 0);
        chk(!err, "R1", "err after reset", err, 0);
        rst_n = 1'b1;
        while (seen_rx_phases < 5) begin
            drive(1'b0);
            model_step();
            @(negedge clk);
            compare();
        end
        // R2: each burst carried exactly DEPTH bytes
        chk(seen_tx_bytes == seen_tx_phases * DEPTH, "R2", "bytes sent per burst",
            seen_tx_bytes, seen_tx_phases * DEPTH);
        // R6 R8: headers dropped, DEPTH payload bytes per receive phase
        chk(seen_cod_bytes == seen_rx_phases * DEPTH, "R6 R8", "bytes to codec per phase",
            seen_cod_bytes, seen_rx_phases * DEPTH);
        chk(err == 1'b0, "R10", "no error under matched traffic", err, 0);
        for (int i = 0; i < 300; i++) begin
            drive(1'b1);
            model_step();
            @(negedge clk);
            compare();
        end
        chk(err == 1'b1, "R10", "err after codec flood", err, 1);
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
        summary();
    end

endmodule